// File: doc/BRIEF.md
# Bitplane shifter pixel pipeline

This block turns bitplane words written over a bus into a stream of palette colours for a retro video display. Each strobe on an active-low load input stores one 16-bit word into the next of four plane input registers. A pixel counter, preset at the start of each active stretch, decides when all four input registers are copied at once into the per-plane shift registers. Each shift register then moves left by one bit per pixel tick.

The bits leaving the shift array are combined into a colour index. The number of planes that feed the index depends on the resolution mode. The index is captured on one pixel tick, and the palette read is captured on the next. That fixed two-stage delay, together with the counter preset, sets the pixel at which the first word becomes visible.

The whole block runs on one system clock. A base pixel enable drives an internal prescaler that produces the pixel tick for each mode. No clock is ever muxed or used as data.

Top module: `bitplane_shifter`

## Requirements
- R1: A falling edge of the synchronised `load_ni` while the synchronised `cs_ni` is high stores `data_i` into plane register 0, then 1, 2, 3, then 0 again. Writing six words leaves words 5 and 6 in planes 0 and 1.
- R2: While `de_i` is low at a pixel tick, the pixel counter is preset to 4 and the shift registers are cleared. With `de_i` high, the counter counts up by one per tick. On the tick where it holds 15, all four input registers are copied into the shift registers together and the counter goes to 0. So the first reload falls on the 12th tick with `de_i` high, and a new reload follows every 16 ticks.
- R3: A 2-bit prescaler is cleared by reset and advances on every cycle with `pix_en_i` high. The pixel tick is every `pix_en_i` cycle in monochrome, the cycles where the prescaler's bit 0 is 1 in medium resolution, and the cycles where the prescaler equals 3 in low resolution.
- R4: The colour index is formed from the planes as follows:
  - Low resolution (`res_i` = 00): the index is {plane3, plane2, plane1, plane0}.
  - Medium resolution (`res_i` = 01): the index is {0, 0, plane1, plane0}.
- R5: In monochrome (`res_i` = 1x), the palette is bypassed. `rgb_o` is all zeros when the plane 0 bit is 0 and all ones when it is 1.
- R6: The index and the palette read are each registered on a pixel tick. Bit 15 of the first reloaded word reaches `rgb_o` after the 14th tick with `de_i` high.
- R7: Two ticks after `de_i` has been sampled low, `rgb_o` shows palette entry 0.
- R8: A palette write through `pal_we_i`/`pal_addr_i`/`pal_data_i` is used by the next pixel tick's lookup. `rgb_o` does not change before that tick.
- R9: When the synchronised `load_ni` and `cs_ni` are both low, the block performs a soft reset. The soft reset clears the resolution mode to low, the plane word index, the prescaler and the shift state, and stores no word.
- R10: After `rst_ni` is asserted, `rgb_o` is zero and the resolution mode is low.
- R11: Each plane shifts out its bit 15 first, then the following bits in descending order, one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_en_i | input | 1 | Base pixel enable (monochrome rate) |
| load_ni | input | 1 | Active-low word load strobe (asynchronous) |
| cs_ni | input | 1 | Active-low chip select (asynchronous) |
| data_i | input | 16 | Bitplane word bus |
| res_we_i | input | 1 | Resolution register write enable |
| res_i | input | 2 | Resolution: 00 low, 01 medium, 1x monochrome |
| de_i | input | 1 | Display enable |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | 4 | Palette write address |
| pal_data_i | input | 12 | Palette write colour |
| rgb_o | output | 12 | Registered output colour |

## Verification
The colour output moves only on pixel tick edges. The bench therefore keeps its own prescaler model of the tick schedule from R3 and counts ticks from the cycle where display enable rises. From that count it expects the border colour up to tick 1 and index-zero colour up to tick 13. From tick 14 on, it expects the shifted pattern, and it checks that the pattern continues without a gap across the next reload at tick 30.

Word writes complete about three clocks after the strobe falls, so each load holds the strobe for four clocks and waits four more. Palette writes are made with the enable low, and checked before and after the next tick. Every sample is taken on the falling clock edge.

// File: rtl/bitplane_shifter_pkg.sv
package bitplane_shifter_pkg;
  typedef enum logic [1:0] {
    RES_LOW  = 2'b00,
    RES_MED  = 2'b01,
    RES_MONO = 2'b10,
    RES_MONB = 2'b11
  } res_e;

  function automatic logic is_mono(res_e r);
    return r[1];
  endfunction
endpackage

// File: rtl/bsh_load_sync.sv
module bsh_load_sync #(
  parameter int WORD_W      = 16,
  parameter int PLANES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_ni,
  input  logic                           cs_ni,
  input  logic [WORD_W-1:0]              data_i,
  output logic [PLANES-1:0][WORD_W-1:0]  planes_o,
  output logic                           soft_rst_o
);
  localparam int IDX_W = (PLANES > 1) ? $clog2(PLANES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PLANES - 1);

  logic [SYNC_STAGES-1:0] ld_sync, cs_sync;
  logic                   ld_prev;
  logic                   ld_q, cs_q, wr;
  logic [IDX_W-1:0]       widx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_sync <= '1;
      cs_sync <= '1;
      ld_prev <= 1'b1;
    end else begin
      ld_sync <= {ld_sync[SYNC_STAGES-2:0], load_ni};
      cs_sync <= {cs_sync[SYNC_STAGES-2:0], cs_ni};
      ld_prev <= ld_q;
    end
  end

  assign ld_q       = ld_sync[SYNC_STAGES-1];
  assign cs_q       = cs_sync[SYNC_STAGES-1];
  assign soft_rst_o = ~ld_q & ~cs_q;
  assign wr         = ld_prev & ~ld_q & cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         widx <= '0;
    else if (soft_rst_o) widx <= '0;
    else if (wr)         widx <= (widx == LAST) ? '0 : widx + 1'b1;
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          planes_o[p] <= '0;
      else if (wr && widx == IDX_W'(p))     planes_o[p] <= data_i;
    end
  end

  assert_widx_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !soft_rst_o) |=> (widx == (($past(widx) == LAST) ? '0 : $past(widx) + 1'b1)));

  assert_soft_idx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (widx == '0));
endmodule

// File: rtl/bsh_shift_array.sv
module bsh_shift_array
  import bitplane_shifter_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PLANES     = 4,
  parameter int CNT_W      = 4,
  parameter int CNT_PRESET = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           soft_rst_i,
  input  logic                           pix_en_i,
  input  res_e                           res_i,
  input  logic                           de_i,
  input  logic [PLANES-1:0][WORD_W-1:0]  planes_i,
  output logic                           tick_o,
  output logic [PLANES-1:0]              bits_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] PRESET  = CNT_W'(CNT_PRESET);

  logic [1:0]       pre;
  logic [CNT_W-1:0] cnt;
  logic             reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre <= '0;
    else if (soft_rst_i) pre <= '0;
    else if (pix_en_i)   pre <= pre + 1'b1;
  end

  // Mode-dependent pixel tick from the base enable
  always_comb begin
    case (res_i)
      RES_LOW: tick_o = pix_en_i & (pre == 2'b11);
      RES_MED: tick_o = pix_en_i & pre[0];
      default: tick_o = pix_en_i;
    endcase
  end

  assign reload = tick_o & de_i & (cnt == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt <= PRESET;
    else if (soft_rst_i) cnt <= PRESET;
    else if (tick_o) begin
      if (!de_i)       cnt <= PRESET;
      else if (reload) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_sh
    logic [WORD_W-1:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         sh <= '0;
      else if (soft_rst_i) sh <= '0;
      else if (tick_o) begin
        if (!de_i)       sh <= '0;
        else if (reload) sh <= planes_i[p];
        else             sh <= {sh[WORD_W-2:0], 1'b0};
      end
    end
    assign bits_o[p] = sh[WORD_W-1];
  end

  assert_preset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !de_i) |=> (cnt == PRESET));

  assert_reload_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && !soft_rst_i) |=> (cnt == '0));

  assert_low_rate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && res_i == RES_LOW) |=> !(tick_o && res_i == RES_LOW));
endmodule

// File: rtl/bsh_color_out.sv
module bsh_color_out
  import bitplane_shifter_pkg::*;
#(
  parameter int PLANES  = 4,
  parameter int COLOR_W = 12,
  parameter int PAL_N   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       de_i,
  input  res_e                       res_i,
  input  logic [PLANES-1:0]          bits_i,
  input  logic                       pal_we_i,
  input  logic [$clog2(PAL_N)-1:0]   pal_addr_i,
  input  logic [COLOR_W-1:0]         pal_data_i,
  output logic [COLOR_W-1:0]         rgb_o
);
  localparam int IDX_W = $clog2(PAL_N);

  logic [COLOR_W-1:0] pal_q [PAL_N];
  logic [IDX_W-1:0]   sel, idx_q;
  logic               de1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAL_N; i++) pal_q[i] <= '0;
    end else if (pal_we_i) begin
      pal_q[pal_addr_i] <= pal_data_i;
    end
  end

  always_comb begin
    sel = '0;
    case (res_i)
      RES_LOW: sel = bits_i[IDX_W-1:0];
      RES_MED: sel[1:0] = bits_i[1:0];
      default: sel[0] = bits_i[0];
    endcase
  end

  // Stage 1: index select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      de1_q <= 1'b0;
    end else if (tick_i) begin
      idx_q <= sel;
      de1_q <= de_i;
    end
  end

  // Stage 2: palette read or monochrome bypass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_o <= '0;
    else if (tick_i) begin
      if (!de1_q)              rgb_o <= pal_q[0];
      else if (is_mono(res_i)) rgb_o <= {COLOR_W{idx_q[0]}};
      else                     rgb_o <= pal_q[idx_q];
    end
  end

  assert_mono_bw_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && de1_q && is_mono(res_i)) |=> (rgb_o == '0 || rgb_o == '1));

  assert_border_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !de1_q && !pal_we_i) |=> (rgb_o == pal_q[0]));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(rgb_o));
endmodule

// File: rtl/bitplane_shifter.sv
module bitplane_shifter
  import bitplane_shifter_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int PLANES      = 4,
  parameter int COLOR_W     = 12,
  parameter int PAL_N       = 16,
  parameter int CNT_W       = 4,
  parameter int CNT_PRESET  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pix_en_i,
  input  logic                      load_ni,
  input  logic                      cs_ni,
  input  logic [WORD_W-1:0]         data_i,
  input  logic                      res_we_i,
  input  logic [1:0]                res_i,
  input  logic                      de_i,
  input  logic                      pal_we_i,
  input  logic [$clog2(PAL_N)-1:0]  pal_addr_i,
  input  logic [COLOR_W-1:0]        pal_data_i,
  output logic [COLOR_W-1:0]        rgb_o
);
  logic [PLANES-1:0][WORD_W-1:0] planes;
  logic [PLANES-1:0]             bits;
  logic                          soft_rst, tick;
  res_e                          res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       res_q <= RES_LOW;
    else if (soft_rst) res_q <= RES_LOW;
    else if (res_we_i) res_q <= res_e'(res_i);
  end

  bsh_load_sync #(
    .WORD_W(WORD_W), .PLANES(PLANES), .SYNC_STAGES(SYNC_STAGES)
  ) u_load (
    .clk_i, .rst_ni, .load_ni, .cs_ni, .data_i,
    .planes_o(planes), .soft_rst_o(soft_rst)
  );

  bsh_shift_array #(
    .WORD_W(WORD_W), .PLANES(PLANES), .CNT_W(CNT_W), .CNT_PRESET(CNT_PRESET)
  ) u_shift (
    .clk_i, .rst_ni, .soft_rst_i(soft_rst), .pix_en_i, .res_i(res_q), .de_i,
    .planes_i(planes), .tick_o(tick), .bits_o(bits)
  );

  bsh_color_out #(
    .PLANES(PLANES), .COLOR_W(COLOR_W), .PAL_N(PAL_N)
  ) u_color (
    .clk_i, .rst_ni, .tick_i(tick), .de_i, .res_i(res_q), .bits_i(bits),
    .pal_we_i, .pal_addr_i, .pal_data_i, .rgb_o
  );

  assert_res_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (res_q == RES_LOW));
endmodule

// File: tb/bitplane_shifter_tb.sv
module bitplane_shifter_tb;
  logic        clk = 0;
  logic        rst_ni = 0;
  logic        pix_en = 0, load_n = 1, cs_n = 1;
  logic [15:0] data = '0;
  logic        res_we = 0, de = 0, pal_we = 0;
  logic [1:0]  res = '0;
  logic [3:0]  pal_addr = '0;
  logic [11:0] pal_data = '0;
  logic [11:0] rgb;

  int checks = 0, errors = 0;
  logic [1:0]  cur_mode = 2'b00;
  logic [15:0] exp_w [4];
  logic [11:0] exp_pal [16];
  int          bwidx = 0;
  logic [31:0] bc = '0;
  logic        bc_clr = 1;
  logic        tick_seen = 0;

  always #4 clk = ~clk;

  bitplane_shifter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_en_i(pix_en), .load_ni(load_n), .cs_ni(cs_n),
    .data_i(data), .res_we_i(res_we), .res_i(res), .de_i(de), .pal_we_i(pal_we),
    .pal_addr_i(pal_addr), .pal_data_i(pal_data), .rgb_o(rgb)
  );

  // Tick schedule model from R3
  always @(posedge clk) begin
    if (bc_clr) begin
      bc <= '0;
      tick_seen <= 1'b0;
    end else begin
      tick_seen <= pix_en && (cur_mode[1] || (cur_mode == 2'b01 && bc[0]) ||
                              (cur_mode == 2'b00 && bc[1:0] == 2'b11));
      bc <= bc + {31'd0, pix_en};
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk); data = w; load_n = 0;
    repeat (4) @(negedge clk);
    load_n = 1;
    repeat (4) @(negedge clk);
    exp_w[bwidx] = w;
    bwidx = (bwidx + 1) % 4;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); pix_en = 0; res = m; res_we = 1;
    @(negedge clk); res_we = 0; cur_mode = m;
  endtask

  task automatic write_pal(input int a, input logic [11:0] d);
    @(negedge clk); pal_addr = a[3:0]; pal_data = d; pal_we = 1;
    @(negedge clk); pal_we = 0;
    exp_pal[a] = d;
  endtask

  task automatic soft_reset();
    @(negedge clk); pix_en = 0; load_n = 0; cs_n = 0;
    repeat (6) @(negedge clk);
    load_n = 1; cs_n = 1;
    repeat (6) @(negedge clk);
    bc_clr = 1;
    @(negedge clk); bc_clr = 0;
    bwidx = 0;
    cur_mode = 2'b00;
  endtask

  task automatic wait_ticks(input int k);
    int got = 0;
    while (got < k) begin
      @(negedge clk);
      if (tick_seen) got++;
    end
  endtask

  function automatic logic [11:0] expect_at(input int n);
    int p, b;
    logic [3:0] idx;
    if (n <= 1) return exp_pal[0];
    if (n <= 13) return cur_mode[1] ? 12'h000 : exp_pal[0];
    p = n - 14;
    b = 15 - (p % 16);
    if (cur_mode[1]) return exp_w[0][b] ? 12'hFFF : 12'h000;
    if (cur_mode == 2'b01) idx = {2'b00, exp_w[1][b], exp_w[0][b]};
    else idx = {exp_w[3][b], exp_w[2][b], exp_w[1][b], exp_w[0][b]};
    return exp_pal[idx];
  endfunction

  // R2 R4 R5 R6 R7 R11: one display stretch with tick-exact expectations
  task automatic run_line(input string req, input int npix);
    int n = 0;
    @(negedge clk); pix_en = 1; de = 0;
    wait_ticks(3);
    chk("R7 border", rgb, exp_pal[0]);
    de = 1;
    while (n < 14 + npix) begin
      @(negedge clk);
      if (tick_seen) n++;
      chk(req, rgb, expect_at(n));
    end
    de = 0;
    wait_ticks(3);
    chk("R7 border after", rgb, exp_pal[0]);
    pix_en = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1;
    bc_clr = 0;
    @(negedge clk);
    chk("R10 reset rgb", rgb, 12'h000);
    for (int i = 0; i < 16; i++) exp_pal[i] = 12'h000;

    for (int i = 0; i < 16; i++) write_pal(i, 12'(i * 12'h111) ^ 12'h0A5);
    load_word(16'hA5C3); load_word(16'h0FF0); load_word(16'h3C96); load_word(16'hF00F);
    run_line("R10 R4 R6 R11 low default", 40);

    set_mode(2'b01);
    run_line("R3 R4 medium", 40);
    set_mode(2'b10);
    run_line("R3 R5 mono", 40);
    set_mode(2'b11);
    run_line("R5 mono alt code", 20);

    // R8: palette update seen by next lookup only
    set_mode(2'b00);
    @(negedge clk); pix_en = 1; de = 0;
    wait_ticks(3);
    pix_en = 0;
    write_pal(0, 12'h5E1);
    chk("R8 before tick", rgb, 12'h0A5);
    @(negedge clk); pix_en = 1;
    wait_ticks(1);
    chk("R8 after tick", rgb, 12'h5E1);
    pix_en = 0;

    // R1: six loads wrap the plane index
    for (int i = 0; i < 6; i++) load_word(16'h1357 * 16'(i + 3));
    run_line("R1 wrap low", 34);

    // R9: soft reset clears mode and word index
    set_mode(2'b10);
    load_word(16'hDEAD); load_word(16'hBEEF);
    soft_reset();
    for (int i = 0; i < 4; i++) load_word(16'h2B4D ^ 16'(i * 16'h1111));
    run_line("R9 soft reset", 34);

    // Sweep: patterns by mode
    for (int k = 0; k < 3; k++) begin
      for (int m = 0; m < 3; m++) begin
        for (int i = 0; i < 4; i++) load_word(16'(16'h6B1D * (k + 1)) ^ 16'(i * 16'h0F1E));
        set_mode(m == 2 ? 2'b10 : 2'(m));
        run_line("R2 R4 R5 sweep", 36);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule